// File: doc/BRIEF.md
# Even-Ratio Glitch-Free Clock Divider

This block derives a slower clock from one incoming clock. A 3-bit select picks an even division ratio between 2 and 16. The output always has a 50% duty cycle: the high and low phases are each exactly half the ratio, counted in input clock cycles. The output comes straight from a flop, so it carries no combinational glitches.

A synchronous divider reset stops and restarts the output without ever producing a shortened pulse. If the reset arrives during a high phase, that phase runs to its full length before the output is held low. A new select value is adopted only when the output falls, so every period is built from one ratio.

Divide-by-2 is meant to be paired with registers that capture on both clock edges. These registers then update once per input cycle, while the clock net toggles at half the rate.

Top module: `even_clk_div`

## Requirements
- R1: The select encodes the ratio as 2*(sel+1): 3'b000 gives divide-by-2, 3'b011 gives divide-by-8, and 3'b111 gives divide-by-16. One output period lasts exactly that many input cycles.
- R2: With the synchronous reset low, every high phase and every low phase lasts exactly sel+1 input cycles (50% duty).
- R3: At each rising input edge where the synchronous reset is sampled high while the output is low, three things happen:
  - the output stays low;
  - the phase count restarts;
  - the select is reloaded.
- R4: A synchronous reset that is raised during a high phase does not shorten it. The high phase completes its full sel+1 cycles, and then the output goes low and stays low.
- R5: After the synchronous reset is released, the output rises at the (sel+1)-th rising edge at which the reset is sampled low. It is therefore low for sel full cycles after the release.
- R6: A change of select takes effect at the next falling edge of the output. The phases in progress keep the old ratio, and the following low and high phases use the new one.
- R7: Select changes made while the synchronous reset holds the output low have no effect. Only the value present at the last held edge sets the first period after release.
- R8: While the active-low asynchronous reset is low, the output is low. After its release, the output stays low for two synchronizing edges and one select-loading edge, and then counts. The first rise comes at the (sel+4)-th rising edge.
- R9: With select 3'b000, the output toggles on every rising input edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Incoming clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_srst_i | input | 1 | Synchronous divider reset, active high |
| ratio_sel_i | input | 3 | Ratio select, ratio = 2*(value+1) |
| clk_div_o | output | 1 | Divided 50% duty-cycle clock |

## Verification
The hardest situations to reach are events that land partway through a phase:
- a synchronous reset raised in the middle of a high phase;
- a select change made while a period is still running.

The bench reaches them by watching the output at falling input edges. It waits for a chosen sample inside a high phase and changes the input exactly there. It then measures the run lengths of the following phases against the ratio each should use. A behavioural model steps alongside on every clock so that any stray edge is caught.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int SEL_W_DEF       = 3;
  localparam int SYNC_STAGES_DEF = 2;

  typedef enum logic [1:0] {
    DV_BOOT = 2'd0,
    DV_LOW  = 2'd1,
    DV_HIGH = 2'd2
  } div_state_e;
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sh_q[STAGES-1];
endmodule

// File: rtl/clkdiv_ratio_reg.sv
module clkdiv_ratio_reg #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] term_o
);
  logic [SEL_W-1:0] term_q, term_d;

  // Terminal count of one phase equals the select: phase = sel+1 cycles.
  always_comb begin
    term_d = term_q;
    if (load_i) term_d = sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) term_q <= '0;
    else         term_q <= term_d;
  end

  assign term_o = term_q;
endmodule

// File: rtl/clkdiv_half_cnt.sv
module clkdiv_half_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign wrap_o = (cnt_q == term_i);
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic wrap_i,
  output logic load_o,
  output logic clr_o,
  output logic inc_o,
  output logic div_o
);
  div_state_e state_q, state_d;
  logic       div_q;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    unique case (state_q)
      DV_BOOT: begin
        load_o  = 1'b1;
        clr_o   = 1'b1;
        state_d = DV_LOW;
      end
      DV_LOW: begin
        if (srst_i) begin
          load_o = 1'b1;
          clr_o  = 1'b1;
        end else if (wrap_i) begin
          clr_o   = 1'b1;
          state_d = DV_HIGH;
        end else begin
          inc_o = 1'b1;
        end
      end
      DV_HIGH: begin
        // reset request is deferred until the high phase ends
        if (wrap_i) begin
          clr_o   = 1'b1;
          load_o  = 1'b1;
          state_d = DV_LOW;
        end else begin
          inc_o = 1'b1;
        end
      end
      default: begin
        state_d = DV_BOOT;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DV_BOOT;
      div_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      div_q   <= (state_d == DV_HIGH);
    end
  end

  assign div_o = div_q;
endmodule

// File: rtl/even_clk_div.sv
module even_clk_div
  import clkdiv_pkg::*;
#(
  parameter int SEL_W       = SEL_W_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_srst_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  output logic             clk_div_o
);
  localparam int CNT_W = SEL_W;

  logic             rst_int_n;
  logic             load, clr, inc, wrap;
  logic [CNT_W-1:0] term;

  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  clkdiv_ratio_reg #(.SEL_W(SEL_W)) u_ratio (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .load_i (load),
    .sel_i  (ratio_sel_i),
    .term_o (term)
  );

  clkdiv_half_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .clr_i  (clr),
    .inc_i  (inc),
    .term_i (term),
    .wrap_o (wrap)
  );

  clkdiv_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .srst_i (div_srst_i),
    .wrap_i (wrap),
    .load_o (load),
    .clr_o  (clr),
    .inc_o  (inc),
    .div_o  (clk_div_o)
  );
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker #(
  parameter int SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             div_srst_i,
  input logic [SEL_W-1:0] ratio_sel_i,
  input logic             clk_div_o
);
  logic             out_d, srst_d, armed_q;
  logic [SEL_W-1:0] sel_d;
  logic [15:0]      run_q, cur_half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_d      <= 1'b0;
      srst_d     <= 1'b0;
      sel_d      <= '0;
      armed_q    <= 1'b0;
      run_q      <= '0;
      cur_half_q <= '0;
    end else begin
      out_d  <= clk_div_o;
      srst_d <= div_srst_i;
      sel_d  <= ratio_sel_i;
      if (clk_div_o != out_d)  run_q <= 16'd1;
      else if (run_q != '1)    run_q <= run_q + 16'd1;
      if ((out_d && !clk_div_o) || (srst_d && !out_d)) begin
        cur_half_q <= 16'(sel_d) + 16'd1;
        armed_q    <= 1'b1;
      end
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      AST_ASYNC_LOW: assert (!clk_div_o); // R8
    end
  end

  AST_SRST_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_d && !out_d) |-> !clk_div_o); // R3

  AST_HIGH_FULL_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && out_d && !clk_div_o) |-> (run_q == cur_half_q)); // R4

  AST_RISE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_d && clk_div_o) |-> !srst_d); // R5

  AST_HIGH_RATIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && out_d && !clk_div_o && !srst_d) |-> (run_q <= 16'(1 << SEL_W))); // R6
endmodule

bind even_clk_div clkdiv_checker #(.SEL_W(SEL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .div_srst_i  (div_srst_i),
  .ratio_sel_i (ratio_sel_i),
  .clk_div_o   (clk_div_o)
);

// File: tb/tb_even_clk_div.sv
`timescale 1ns/1ps
module tb_even_clk_div;
  logic       clk, rst_n, srst, div_o;
  logic [2:0] sel;
  int n_chk, n_fail;

  even_clk_div dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .div_srst_i  (srst),
    .ratio_sel_i (sel),
    .clk_div_o   (div_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference model
  int   m_wait, m_cnt, m_half;
  logic m_out;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wait = 3; m_cnt = 0; m_half = 1; m_out = 1'b0;
    end else if (m_wait > 0) begin
      if (m_wait == 1) begin m_half = int'(sel) + 1; m_cnt = 0; end
      m_wait = m_wait - 1;
    end else if (!m_out && srst) begin
      m_cnt = 0; m_half = int'(sel) + 1;
    end else if (m_cnt == m_half - 1) begin
      m_cnt = 0;
      m_out = !m_out;
      if (!m_out) m_half = int'(sel) + 1;
    end else begin
      m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n !== 1'bx) begin
      n_chk++;
      if (div_o !== m_out) begin
        n_fail++;
        $display("FAIL R1/R2 model compare at %0t: actual %b expected %b", $time, div_o, m_out);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_run(input logic v, output int n);
    n = 0;
    while (div_o === v && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic sreset(input logic [2:0] s);
    @(negedge clk); #1 srst = 1'b1; sel = s;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n, lo, hi, tog;
    logic prev;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b1; srst = 1'b0; sel = 3'd0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(div_o === 1'b0, "R8 low in async reset", int'(div_o), 0);
    #1 sel = 3'd2; rst_n = 1'b1;
    @(negedge clk);
    count_run(1'b0, n);
    check(n == 5, "R8 first rise after async release", n, 5);

    for (int s = 0; s < 8; s++) begin
      sreset(3'(s));
      check(div_o === 1'b0, "R3 held low", int'(div_o), 0);
      #1 srst = 1'b0;
      @(negedge clk);
      count_run(1'b0, n);
      check(n == s, "R5 low cycles after release", n, s);
      count_run(1'b1, hi);
      check(hi == s + 1, "R2 high phase", hi, s + 1);
      count_run(1'b0, lo);
      check(lo == s + 1, "R2 low phase", lo, s + 1);
      check(hi + lo == 2 * (s + 1), "R1 period", hi + lo, 2 * (s + 1));
    end

    sreset(3'd0);
    #1 srst = 1'b0;
    @(negedge clk);
    prev = div_o; tog = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (div_o !== prev) tog++;
      prev = div_o;
    end
    check(tog == 10, "R9 toggle every edge", tog, 10);

    sreset(3'd3);
    #1 srst = 1'b0;
    @(negedge clk);
    count_run(1'b0, n);
    #1 sel = 3'd1;
    count_run(1'b1, hi);
    check(hi == 4, "R6 high keeps old ratio", hi, 4);
    count_run(1'b0, lo);
    check(lo == 2, "R6 low uses new ratio", lo, 2);
    count_run(1'b1, hi);
    check(hi == 2, "R6 high uses new ratio", hi, 2);

    sreset(3'd3);
    #1 srst = 1'b0;
    @(negedge clk);
    count_run(1'b0, n);
    @(negedge clk);
    #1 srst = 1'b1;
    count_run(1'b1, hi);
    check(hi == 3, "R4 high completes after request", hi, 3);
    count_run(1'b0, lo);
    check(lo == 200, "R4 held low after high", lo, 200);

    @(negedge clk); #1 sel = 3'd5;
    repeat (4) @(negedge clk);
    #1 sel = 3'd1;
    @(negedge clk);
    #1 srst = 1'b0;
    @(negedge clk);
    count_run(1'b0, n);
    check(n == 1, "R7 last held select governs", n, 1);
    count_run(1'b1, hi);
    check(hi == 2, "R7 first high phase", hi, 2);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule